// File: doc/BRIEF.md
# Paged EEPROM Write Controller Model

This block is a clocked model of the control logic inside a byte-wide paged nonvolatile memory. Its host side looks like a static RAM. There is an active-low chip select, an active-low output enable, an active-low write enable, a 17-bit address and 8-bit read and write data buses. Write strobes are qualified and filtered first. Each accepted byte is then placed in a 128-byte page buffer. A byte-load window restarts with every accepted byte. When the window runs out, the buffered page is programmed during a timed internal cycle. At the end of that cycle, only the byte slots that were actually loaded are written into a small register array.

While programming runs, the block stays readable but reports status instead of plain data. A read of the byte written last returns the complement of its bit 7. Every read also sees bit 6 change from one read access to the next. Write strobes are ignored until the cycle ends. After the cycle ends, reads return the stored data. A byte that tries to join a load from a different page is dropped, and a sticky error flag is set.

The array depth, the minimum strobe length, the byte-load window and the programming time are parameters. The window and the programming time are counted in clock cycles.

Top module: `pgeep_ctrl`

## Requirements
- R1: After reset, `busy` and `page_err` are 0 and every array byte reads as 0x00.
- R2: `rdata_oe` is 1 exactly when `cs_n` and `oe_n` are both 0. While `rdata_oe` is 0, `rdata` is 0x00.
- R3: A write strobe counts only while `cs_n`=0, `we_n`=0 and `oe_n`=1. The strobe must be held for at least MIN_PULSE sampled clock edges. Shorter strobes, strobes with `oe_n`=0 and strobes with `cs_n`=1 change nothing.
- R4: Programming (`busy`=1) is first seen LOAD_WIN+1 cycles after the strobe release of the last accepted byte. Every accepted byte restarts the window.
- R5: Bytes of one load may arrive in any order, and the last value loaded into a slot wins. At commit, only loaded slots change, and the page buffer is empty again.
- R6: While `busy`=1, a read of the byte written last returns bit 7 inverted with respect to the written data.
- R7: While `busy`=1, bit 6 of read data is 0 on the first read access and flips after each completed read access. Bits 5..0 return the array's stored contents.
- R8: `busy` stays 1 for exactly PROG_CYC cycles. Write strobes during that time are ignored. Afterwards, reads return true data on all bits.
- R9: A byte whose page number (address bits 16..7) differs from that of the first byte of the load is not stored. It sets `page_err`, which stays 1 until reset.
- R10: The address is taken at the cycle the write strobe becomes active. The data is the last value sampled before the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address: bits 16..7 page, bits 6..0 byte in page |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or polling status |
| rdata_oe | output | 1 | Read data drive enable (1 = driven, 0 = high impedance) |
| busy | output | 1 | Internal programming in progress |
| page_err | output | 1 | Sticky flag for a byte that crossed pages |

## Verification
Page loads are tried in several forms. One load uses out-of-order bytes with an overwrite of the same slot, another is a single byte, and another is disturbed by a byte from a foreign page. Together they tell apart a commit of loaded slots only, last-value-wins and the page-mismatch drop. Strobes that are too short, that occur with output enable low, or that occur with chip select high must not start a load. A strobe whose address and data change while it is held separates the capture of the address at the start from the capture of the data at the end. Back-to-back reads during programming, at the address written last and at another address, separate the inverted bit 7 from the alternating bit 6. Measuring the cycle counts to and across `busy` pins down the load window and the programming length.

// File: rtl/pgeep_pkg.sv
`timescale 1ns/1ps
package pgeep_pkg;
   localparam int ADDR_W     = 17;
   localparam int DATA_W     = 8;
   localparam int PAGE_AW    = 7;
   localparam int PAGE_BYTES = 1 << PAGE_AW;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pstate_t;
endpackage

// File: rtl/pgeep_strobe.sv
`timescale 1ns/1ps
module pgeep_strobe #(
   parameter int MIN_PULSE = 2,
   parameter int AW        = 17,
   parameter int DW        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          acc,
   output logic [AW-1:0] acc_addr,
   output logic [DW-1:0] acc_data,
   output logic          rd_end
);
   logic wr_act, rd_act, wr_q, rd_q, pulse_ok;

   assign wr_act = !cs_n && !we_n && oe_n;
   assign rd_act = !cs_n && !oe_n && we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b0;
         rd_q     <= 1'b0;
         acc_addr <= '0;
         acc_data <= '0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
         if (wr_act && !wr_q) acc_addr <= addr;
         if (wr_act)          acc_data <= wdata;
      end
   end

   generate
      if (MIN_PULSE > 1) begin : g_filt
         localparam int CW = $clog2(MIN_PULSE + 1);
         logic [CW-1:0] len_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  len_q <= '0;
            else if (wr_act && !wr_q)                    len_q <= CW'(1);
            else if (wr_act && len_q != CW'(MIN_PULSE))  len_q <= len_q + 1'b1;
         end
         assign pulse_ok = (len_q == CW'(MIN_PULSE));
      end else begin : g_nofilt
         assign pulse_ok = 1'b1;
      end
   endgenerate

   assign acc    = wr_q && !wr_act && pulse_ok;
   assign rd_end = rd_q && !rd_act;
endmodule

// File: rtl/pgeep_timer.sv
`timescale 1ns/1ps
module pgeep_timer
   import pgeep_pkg::*;
#(
   parameter int LOAD_WIN = 7500,
   parameter int PROG_CYC = 500000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    take,
   output pstate_t st,
   output logic    commit
);
   localparam int MAXC = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;

   assign commit = (st == ST_PROG) && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: if (take) begin
               st  <= ST_LOAD;
               cnt <= CW'(LOAD_WIN);
            end
            ST_LOAD: begin
               if (take)                 cnt <= CW'(LOAD_WIN);
               else if (cnt == CW'(1)) begin
                  st  <= ST_PROG;
                  cnt <= CW'(PROG_CYC);
               end else                  cnt <= cnt - 1'b1;
            end
            ST_PROG: begin
               if (cnt == CW'(1)) st  <= ST_IDLE;
               else               cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgeep_pagebuf.sv
`timescale 1ns/1ps
module pgeep_pagebuf
   import pgeep_pkg::*;
(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc,
   input  logic [ADDR_W-1:0]            acc_addr,
   input  logic [DATA_W-1:0]            acc_data,
   input  pstate_t                      st,
   input  logic                         commit,
   output logic                         take,
   output logic [ADDR_W-PAGE_AW-1:0]    page_q,
   output logic [PAGE_AW-1:0]           last_off,
   output logic [DATA_W-1:0]            last_data,
   output logic [PAGE_BYTES-1:0]        vmask,
   output logic [PAGE_BYTES*DATA_W-1:0] pbuf_flat,
   output logic                         page_err
);
   logic [DATA_W-1:0]  pbuf [PAGE_BYTES];
   logic [PAGE_AW-1:0] off;
   logic               same_page;

   assign off       = acc_addr[PAGE_AW-1:0];
   assign same_page = (acc_addr[ADDR_W-1:PAGE_AW] == page_q);
   assign take      = acc && ((st == ST_IDLE) || (st == ST_LOAD && same_page));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q    <= '0;
         last_off  <= '0;
         last_data <= '0;
         vmask     <= '0;
         page_err  <= 1'b0;
      end else begin
         if (commit)    vmask      <= '0;
         else if (take) vmask[off] <= 1'b1;
         if (take) begin
            if (st == ST_IDLE) page_q <= acc_addr[ADDR_W-1:PAGE_AW];
            last_off  <= off;
            last_data <= acc_data;
         end
         if (acc && st == ST_LOAD && !same_page) page_err <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (take) pbuf[off] <= acc_data;
   end

   for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_flat
      assign pbuf_flat[b*DATA_W +: DATA_W] = pbuf[b];
   end
endmodule

// File: rtl/pgeep_ctrl.sv
`timescale 1ns/1ps
module pgeep_ctrl
   import pgeep_pkg::*;
#(
   parameter int DEPTH     = 512,
   parameter int LOAD_WIN  = 7500,
   parameter int PROG_CYC  = 500000,
   parameter int MIN_PULSE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              busy,
   output logic              page_err
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW - PAGE_AW;

   if (DEPTH < 2*PAGE_BYTES || (DEPTH & (DEPTH-1)) != 0 || AW > ADDR_W) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least two pages");
   end
   if (LOAD_WIN < 1 || PROG_CYC < 1 || MIN_PULSE < 1) begin : g_bad_time
      $error("LOAD_WIN, PROG_CYC and MIN_PULSE must be at least 1");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("status bits need a data width of at least 8");
   end

   logic                         acc, rd_end, take, commit, tog, hit_last;
   logic [ADDR_W-1:0]            acc_addr;
   logic [DATA_W-1:0]            acc_data, last_data, word, rd_val;
   logic [ADDR_W-PAGE_AW-1:0]    page_q;
   logic [PAGE_AW-1:0]           last_off;
   logic [PAGE_BYTES-1:0]        vmask;
   logic [PAGE_BYTES*DATA_W-1:0] pbuf_flat;
   logic [DEPTH*DATA_W-1:0]      mem_flat;
   pstate_t                      st;

   pgeep_strobe #(.MIN_PULSE(MIN_PULSE), .AW(ADDR_W), .DW(DATA_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .acc(acc), .acc_addr(acc_addr),
      .acc_data(acc_data), .rd_end(rd_end));

   pgeep_pagebuf u_buf (
      .clk(clk), .rst_n(rst_n), .acc(acc), .acc_addr(acc_addr),
      .acc_data(acc_data), .st(st), .commit(commit), .take(take),
      .page_q(page_q), .last_off(last_off), .last_data(last_data),
      .vmask(vmask), .pbuf_flat(pbuf_flat), .page_err(page_err));

   pgeep_timer #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .take(take), .st(st), .commit(commit));

   for (genvar j = 0; j < DEPTH; j++) begin : g_word
      localparam int JB = j % PAGE_BYTES;
      localparam int JP = j / PAGE_BYTES;
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= '0;
         else if (commit && vmask[JB] && page_q[PW-1:0] == PW'(JP))
            word_q <= pbuf_flat[JB*DATA_W +: DATA_W];
      end
      assign mem_flat[j*DATA_W +: DATA_W] = word_q;
   end

   assign busy     = (st == ST_PROG);
   assign word     = mem_flat[int'(addr[AW-1:0])*DATA_W +: DATA_W];
   assign hit_last = (addr[ADDR_W-1:PAGE_AW] == page_q) && (addr[PAGE_AW-1:0] == last_off);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tog <= 1'b0;
      else if (!busy)  tog <= 1'b0;
      else if (rd_end) tog <= ~tog;
   end

   always_comb begin
      rd_val = word;
      if (busy) begin
         rd_val[DATA_W-2] = tog;
         if (hit_last) rd_val[DATA_W-1] = ~last_data[DATA_W-1];
      end
   end

   assign rdata_oe = !cs_n && !oe_n;
   assign rdata    = rdata_oe ? rd_val : '0;
endmodule

// File: rtl/pgeep_chk.sv
`timescale 1ns/1ps
module pgeep_chk
   import pgeep_pkg::*;
#(
   parameter int PROG_CYC = 500000
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  page_err,
   input logic                  rdata_oe,
   input logic [DATA_W-1:0]     rdata,
   input logic [PAGE_BYTES-1:0] vmask
);
   localparam int CW = $clog2(PROG_CYC + 2);
   logic [CW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         bcnt <= '0;
      else if (!busy)                     bcnt <= '0;
      else if (bcnt != CW'(PROG_CYC + 1)) bcnt <= bcnt + 1'b1;
   end

   assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> rdata == '0);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(page_err) |-> page_err);

   assert_prog_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> bcnt < CW'(PROG_CYC));

   assert_buf_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> vmask == '0);
endmodule

bind pgeep_ctrl pgeep_chk #(.PROG_CYC(PROG_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .page_err(page_err),
   .rdata_oe(rdata_oe), .rdata(rdata), .vmask(vmask));

// File: tb/sim_pgeep_ctrl.sv
`timescale 1ns/1ps
module sim_pgeep_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LW   = 8;
   localparam int PC   = 20;
   localparam int MP   = 2;
   localparam int WDOG = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rdata_oe, busy, page_err;

   int   nchk = 0, nerr = 0;
   bit   done = 1'b0;
   event mon_ev;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   pgeep_ctrl #(.DEPTH(512), .LOAD_WIN(LW), .PROG_CYC(PC), .MIN_PULSE(MP)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
      .busy(busy), .page_err(page_err));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when the driver marks a read sample point
   always begin
      @(mon_ev);
      if (exp_q.size() != 0) begin
         logic [7:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {24'd0, rdata}, {24'd0, e});
      end
   end

   task automatic rd(logic [16:0] a, logic [7:0] e, string t);
      @(negedge clk);
      addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(t);
      -> mon_ev;
      @(posedge clk);
      @(negedge clk);
      cs_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wr(logic [16:0] a, logic [7:0] d, int len);
      @(negedge clk);
      addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      repeat (len) @(negedge clk);
      we_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic measure(output int pre, output int len);
      pre = 0;
      while (!busy && pre < 1000) begin @(negedge clk); pre++; end
      len = 0;
      while (busy && len < 1000) begin @(negedge clk); len++; end
   endtask

   task automatic to_busy(output int pre);
      pre = 0;
      while (!busy && pre < 1000) begin @(negedge clk); pre++; end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      int pre, len;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy after reset", busy, 0);
      check("R1 page_err after reset", page_err, 0);
      check("R2 rdata_oe idle", rdata_oe, 0);
      check("R2 rdata idle", rdata, 0);
      rd(17'h00005, 8'h00, "R1 array zero");

      // R2 output enable
      @(negedge clk); cs_n = 1'b0; oe_n = 1'b1;
      @(negedge clk); check("R2 oe_n high", rdata_oe, 0);
      oe_n = 1'b0;
      @(negedge clk); check("R2 both low", rdata_oe, 1);
      cs_n = 1'b1; oe_n = 1'b1;

      // R5 out-of-order page load with overwrite, R4 window from last byte
      wr(17'h00003, 8'h11, 2);
      wr(17'h00001, 8'h22, 2);
      wr(17'h00003, 8'h33, 3);
      wr(17'h0007F, 8'h44, 2);
      to_busy(pre);
      check("R4 window from last byte", pre, LW + 1);
      // R6/R7 polling reads during busy
      rd(17'h0007F, 8'h80, "R6 inverted bit7, R7 first bit6=0");
      rd(17'h0007F, 8'hC0, "R7 second read bit6=1");
      rd(17'h00001, 8'h00, "R7 third read bit6=0, non-last bit7 true");
      wr(17'h00002, 8'h77, 2);   // R8 write during busy, ignored
      while (busy) @(negedge clk);
      check("R9 no error on same-page load", page_err, 0);
      rd(17'h00003, 8'h33, "R5 last value wins");
      rd(17'h00001, 8'h22, "R5 loaded byte");
      rd(17'h0007F, 8'h44, "R8 true data after completion");
      rd(17'h00000, 8'h00, "R5 unloaded slot unchanged");
      rd(17'h00002, 8'h00, "R8 write during busy ignored");

      // R4/R8 single byte timing
      wr(17'h00085, 8'h5A, 3);
      measure(pre, len);
      check("R4 window single byte", pre, LW + 1);
      check("R8 programming length", len, PC);
      rd(17'h00085, 8'h5A, "R8 single byte stored");
      @(negedge clk); addr = 17'h00085; cs_n = 1'b0; oe_n = 1'b1;
      @(negedge clk); check("R2 rdata zero when not enabled", rdata, 0);
      cs_n = 1'b1;

      // R9 page mismatch
      wr(17'h00100, 8'hAB, 2);
      wr(17'h00005, 8'hCD, 2);
      @(negedge clk);
      check("R9 error raised", page_err, 1);
      measure(pre, len);
      rd(17'h00100, 8'hAB, "R9 first page byte stored");
      rd(17'h00005, 8'h00, "R9 foreign byte dropped");
      check("R9 error sticky", page_err, 1);

      // R3 inhibited strobes
      wr(17'h00010, 8'h99, 1);
      repeat (LW + 4) @(negedge clk);
      check("R3 short pulse no load", busy, 0);
      @(negedge clk); addr = 17'h00010; wdata = 8'h98; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
      repeat (3) @(negedge clk); cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (LW + 4) @(negedge clk);
      check("R3 oe_n low no load", busy, 0);
      @(negedge clk); addr = 17'h00010; wdata = 8'h97; cs_n = 1'b1; we_n = 1'b0;
      repeat (3) @(negedge clk); we_n = 1'b1;
      repeat (LW + 4) @(negedge clk);
      check("R3 cs_n high no load", busy, 0);
      rd(17'h00010, 8'h00, "R3 array untouched");

      // R10 address at strobe start, data at strobe end
      @(negedge clk); addr = 17'h00020; wdata = 8'h01; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      @(negedge clk); addr = 17'h00021; wdata = 8'h5C;
      @(negedge clk); we_n = 1'b1; cs_n = 1'b1;
      measure(pre, len);
      check("R10 load started", pre, LW + 1);
      rd(17'h00020, 8'h5C, "R10 start address with end data");
      rd(17'h00021, 8'h00, "R10 later address unused");

      repeat (3) @(negedge clk);
      finish_up();
   end
endmodule